// File: doc/BRIEF.md
# Virtual-to-Physical Translation Controller

This controller takes one virtual address request at a time and turns it into a physical address, a fault code, or a configuration error. It first works out which privilege level the access runs at. Data accesses may borrow the previous privilege through the modify-privilege control, while instruction fetches never do. From that privilege and the satp mode field it picks either pass-through (bare) or three-level Sv39 translation.

For Sv39 it sends a lookup to an external TLB tagged with the satp ASID. On a miss it starts an external page-table walker at the top level. It checks read, write and execute permission itself, both on a TLB hit and on a walk result. It also enforces the accessed and dirty bit rules. A build parameter chooses whether a needed A/D change faults or is written back to memory. After the write-back the TLB entry is refreshed.

The TLB, the walker and the PTE write port each use a valid/response handshake. The controller holds each request until its response arrives.

Top module: `atc_ctrl`

## Requirements
- R1: Effective privilege (encoding U=0, S=1, M=3) is `priv_i` for instruction fetches (`req_fetch_i`=1). For data accesses it is `mpp_i` when `mprv_i` is set, and `priv_i` otherwise.
- R2: When the effective privilege is M, or when `satp_mode_i`=0, the full 64-bit virtual address is returned unchanged with no fault, one cycle after acceptance, and no TLB request is made.
- R3: With `satp_mode_i`=8 and a non-M effective privilege, a TLB lookup is issued with virtual address bits 38..0 and with `satp_asid_i` as the ASID. Bits 63..39 play no part.
- R4: On a TLB hit the stored PTE is checked again for permission. A failure returns a page fault with no memory write and no fill.
- R5: Permission rules use PTE flags R=bit1, W=bit2, X=bit3, U=bit4. In user mode, a read needs U and (R, or X with `mxr_i`). A write needs U and W. An execute needs U and X. In supervisor mode, a read needs (not U, or `sum_i`) and (R, or X with `mxr_i`). A write needs (not U, or `sum_i`) and W. An execute needs not U and X.
- R6: On a miss the walker is asked to start at level 2 with VA bits 38..0. A successful, permitted walk that needs no A/D change fills the TLB with the walk result and returns the walker's physical address in the same cycle.
- R7: An A/D change is needed when A (bit6) is 0, or when the access is a write and D (bit7) is 0. With `UPD_AD`=0 such an access returns a page fault. No memory write and no fill take place.
- R8: With `UPD_AD`=1 the PTE with A set, and D also set for writes, is written to the PTE address. On success the TLB is filled with that PTE and the address is returned. On a write error an access fault is returned and nothing is filled.
- R9: A walker failure code 0 (invalid) or 1 (misaligned) gives a page fault. Code 2 (access) gives an access fault.
- R10: Fault cause codes follow the access type (`req_acc_i` 0=read, 1=write, 2=execute). Access faults are 5, 7 and 1 for read, write and execute. Page faults are 13, 15 and 12.
- R11: Any other satp mode with a non-M effective privilege returns `cfg_err_o` together with `rsp_valid_o`, no fault and no downstream request.
- R12: One transaction is in flight at a time. `req_ready_o` is high only when idle, at most one downstream valid is high, and each valid stays high until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Controller idle, request accepted |
| req_vaddr_i | input | XLEN | Virtual address |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| req_fetch_i | input | 1 | Instruction fetch (1) or data access (0) |
| priv_i | input | 2 | Current privilege |
| mprv_i | input | 1 | Modify-privilege enable |
| mpp_i | input | 2 | Previous privilege |
| mxr_i | input | 1 | Execute-only pages readable |
| sum_i | input | 1 | Supervisor may touch user pages |
| satp_mode_i | input | MODE_W | Translation mode field |
| satp_asid_i | input | ASID_W | Address space identifier |
| rsp_valid_o | output | 1 | Result pulse |
| rsp_paddr_o | output | XLEN | Physical address |
| rsp_fault_o | output | 1 | Result is a fault |
| rsp_cause_o | output | 5 | Fault cause code |
| cfg_err_o | output | 1 | Unsupported translation mode |
| tlb_req_valid_o | output | 1 | TLB lookup request |
| tlb_vaddr_o | output | SV_VA_W | Lookup virtual address |
| tlb_asid_o | output | ASID_W | Lookup ASID |
| tlb_rsp_valid_i | input | 1 | Lookup response |
| tlb_hit_i | input | 1 | Lookup hit |
| tlb_pte_i | input | PTE_W | Stored PTE |
| tlb_paddr_i | input | PA_W | Translated address of hit |
| tlb_pte_addr_i | input | PA_W | Stored PTE address |
| tlb_level_i | input | LVL_W | Stored page level |
| tlb_global_i | input | 1 | Stored global flag |
| walk_req_valid_o | output | 1 | Walk request |
| walk_vaddr_o | output | SV_VA_W | Walk virtual address |
| walk_level_o | output | LVL_W | Starting level |
| walk_rsp_valid_i | input | 1 | Walk response |
| walk_ok_i | input | 1 | Walk found a leaf |
| walk_err_i | input | 2 | Walk failure kind |
| walk_pte_i | input | PTE_W | Leaf PTE |
| walk_paddr_i | input | PA_W | Translated address |
| walk_pte_addr_i | input | PA_W | Leaf PTE address |
| walk_level_i | input | LVL_W | Leaf level |
| walk_global_i | input | 1 | Global mapping seen on path |
| mem_wr_valid_o | output | 1 | PTE write request |
| mem_wr_addr_o | output | PA_W | PTE write address |
| mem_wr_data_o | output | PTE_W | Updated PTE |
| mem_wr_done_i | input | 1 | PTE write response |
| mem_wr_err_i | input | 1 | PTE write failed |
| tlb_fill_valid_o | output | 1 | TLB fill pulse |
| tlb_fill_vaddr_o | output | SV_VA_W | Fill virtual address |
| tlb_fill_asid_o | output | ASID_W | Fill ASID |
| tlb_fill_paddr_o | output | PA_W | Fill physical address |
| tlb_fill_pte_o | output | PTE_W | Fill PTE |
| tlb_fill_pte_addr_o | output | PA_W | Fill PTE address |
| tlb_fill_level_o | output | LVL_W | Fill page level |
| tlb_fill_global_o | output | 1 | Fill global flag |

## Verification
Two builds, one with write-back and one without, get the same stimulus. Their results are compared against separate expected queues, which separates the fault-on-A/D path from the write-back path on identical PTEs. Privilege selection is tried with fetches and data accesses while the modify-privilege control points at machine mode. This shows whether the fetch path wrongly takes the borrowed privilege. Permission is probed with pairs that differ only in U, SUM or MXR, on both TLB hits and walk results. Walker and memory failure kinds are crossed with each access type to pin down every cause code.

// File: rtl/atc_pkg.sv
package atc_pkg;
  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2} acc_e;
  typedef enum logic [2:0] {ST_IDLE, ST_LKP, ST_WALK, ST_MEMW} atc_state_e;
  typedef enum logic {FK_PAGE = 1'b0, FK_ACCESS = 1'b1} fault_kind_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int unsigned MODE_BARE = 0;
  localparam int unsigned MODE_SV39 = 8;

  localparam logic [1:0] WERR_INVALID  = 2'd0;
  localparam logic [1:0] WERR_MISALIGN = 2'd1;
  localparam logic [1:0] WERR_ACCESS   = 2'd2;

  localparam int unsigned PTE_R = 1;
  localparam int unsigned PTE_W = 2;
  localparam int unsigned PTE_X = 3;
  localparam int unsigned PTE_U = 4;
  localparam int unsigned PTE_A = 6;
  localparam int unsigned PTE_D = 7;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned CAUSE_W = 5;
endpackage

// File: rtl/atc_priv_mode.sv
module atc_priv_mode
  import atc_pkg::*;
#(
  parameter int unsigned MODE_W = 4
) (
  input  logic              fetch_i,
  input  logic [1:0]        priv_i,
  input  logic              mprv_i,
  input  logic [1:0]        mpp_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [1:0]        eff_priv_o,
  output logic              bare_o,
  output logic              sv39_o,
  output logic              bad_o
);
  localparam logic [MODE_W-1:0] M_BARE = MODE_W'(MODE_BARE);
  localparam logic [MODE_W-1:0] M_SV39 = MODE_W'(MODE_SV39);

  logic is_m;

  always_comb begin
    eff_priv_o = (!fetch_i && mprv_i) ? mpp_i : priv_i;
    is_m       = (eff_priv_o == PRIV_M);
    bare_o     = is_m || (mode_i == M_BARE);
    sv39_o     = !is_m && (mode_i == M_SV39);
    bad_o      = !bare_o && !sv39_o;
  end
endmodule

// File: rtl/atc_pte_chk.sv
module atc_pte_chk
  import atc_pkg::*;
(
  input  acc_e              acc_i,
  input  logic [1:0]        priv_i,
  input  logic              mxr_i,
  input  logic              sum_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              perm_ok_o,
  output logic              upd_need_o,
  output logic [FLAG_W-1:0] flags_upd_o
);
  logic is_user, priv_ok, rd_ok;

  always_comb begin
    is_user = (priv_i == PRIV_U);
    priv_ok = is_user ? flags_i[PTE_U] : (!flags_i[PTE_U] || sum_i);
    rd_ok   = flags_i[PTE_R] || (flags_i[PTE_X] && mxr_i);
    unique case (acc_i)
      ACC_READ:  perm_ok_o = priv_ok && rd_ok;
      ACC_WRITE: perm_ok_o = priv_ok && flags_i[PTE_W];
      ACC_EXEC:  perm_ok_o = (is_user ? flags_i[PTE_U] : !flags_i[PTE_U]) && flags_i[PTE_X];
      default:   perm_ok_o = 1'b0;
    endcase
    upd_need_o  = !flags_i[PTE_A] || ((acc_i == ACC_WRITE) && !flags_i[PTE_D]);
    flags_upd_o = flags_i;
    flags_upd_o[PTE_A] = 1'b1;
    if (acc_i == ACC_WRITE) flags_upd_o[PTE_D] = 1'b1;
  end
endmodule

// File: rtl/atc_cause.sv
module atc_cause
  import atc_pkg::*;
(
  input  acc_e               acc_i,
  input  fault_kind_e        kind_i,
  output logic [CAUSE_W-1:0] cause_o
);
  always_comb begin
    unique case (acc_i)
      ACC_EXEC:  cause_o = (kind_i == FK_ACCESS) ? 5'd1 : 5'd12;
      ACC_WRITE: cause_o = (kind_i == FK_ACCESS) ? 5'd7 : 5'd15;
      default:   cause_o = (kind_i == FK_ACCESS) ? 5'd5 : 5'd13;
    endcase
  end
endmodule

// File: rtl/atc_ctrl.sv
module atc_ctrl
  import atc_pkg::*;
#(
  parameter int unsigned XLEN      = 64,
  parameter int unsigned SV_VA_W   = 39,
  parameter int unsigned PA_W      = 56,
  parameter int unsigned ASID_W    = 16,
  parameter int unsigned PTE_W     = 64,
  parameter int unsigned LVL_W     = 2,
  parameter int unsigned MODE_W    = 4,
  parameter int unsigned START_LVL = 2,
  parameter bit          UPD_AD    = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [XLEN-1:0]      req_vaddr_i,
  input  logic [1:0]           req_acc_i,
  input  logic                 req_fetch_i,
  input  logic [1:0]           priv_i,
  input  logic                 mprv_i,
  input  logic [1:0]           mpp_i,
  input  logic                 mxr_i,
  input  logic                 sum_i,
  input  logic [MODE_W-1:0]    satp_mode_i,
  input  logic [ASID_W-1:0]    satp_asid_i,
  output logic                 rsp_valid_o,
  output logic [XLEN-1:0]      rsp_paddr_o,
  output logic                 rsp_fault_o,
  output logic [4:0]           rsp_cause_o,
  output logic                 cfg_err_o,
  output logic                 tlb_req_valid_o,
  output logic [SV_VA_W-1:0]   tlb_vaddr_o,
  output logic [ASID_W-1:0]    tlb_asid_o,
  input  logic                 tlb_rsp_valid_i,
  input  logic                 tlb_hit_i,
  input  logic [PTE_W-1:0]     tlb_pte_i,
  input  logic [PA_W-1:0]      tlb_paddr_i,
  input  logic [PA_W-1:0]      tlb_pte_addr_i,
  input  logic [LVL_W-1:0]     tlb_level_i,
  input  logic                 tlb_global_i,
  output logic                 walk_req_valid_o,
  output logic [SV_VA_W-1:0]   walk_vaddr_o,
  output logic [LVL_W-1:0]     walk_level_o,
  input  logic                 walk_rsp_valid_i,
  input  logic                 walk_ok_i,
  input  logic [1:0]           walk_err_i,
  input  logic [PTE_W-1:0]     walk_pte_i,
  input  logic [PA_W-1:0]      walk_paddr_i,
  input  logic [PA_W-1:0]      walk_pte_addr_i,
  input  logic [LVL_W-1:0]     walk_level_i,
  input  logic                 walk_global_i,
  output logic                 mem_wr_valid_o,
  output logic [PA_W-1:0]      mem_wr_addr_o,
  output logic [PTE_W-1:0]     mem_wr_data_o,
  input  logic                 mem_wr_done_i,
  input  logic                 mem_wr_err_i,
  output logic                 tlb_fill_valid_o,
  output logic [SV_VA_W-1:0]   tlb_fill_vaddr_o,
  output logic [ASID_W-1:0]    tlb_fill_asid_o,
  output logic [PA_W-1:0]      tlb_fill_paddr_o,
  output logic [PTE_W-1:0]     tlb_fill_pte_o,
  output logic [PA_W-1:0]      tlb_fill_pte_addr_o,
  output logic [LVL_W-1:0]     tlb_fill_level_o,
  output logic                 tlb_fill_global_o
);
  localparam int unsigned PAD_W = XLEN - PA_W;
  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(START_LVL);

  atc_state_e state_q;

  // captured request
  logic [SV_VA_W-1:0] va_q;
  acc_e               acc_q;
  logic [1:0]         priv_q;
  logic               mxr_q, sum_q;
  logic [ASID_W-1:0]  asid_q;

  // pending entry for write-back and fill
  logic [PTE_W-1:0]   pte_q;
  logic [PA_W-1:0]    pte_addr_q, pa_q;
  logic [LVL_W-1:0]   lvl_q;
  logic               glob_q;

  logic               rsp_valid_q, rsp_fault_q, cfg_err_q, fill_valid_q;
  logic [XLEN-1:0]    rsp_paddr_q;
  logic [4:0]         rsp_cause_q;

  // front-end decode
  logic [1:0] eff_priv;
  logic       is_bare, is_sv39, is_bad;

  atc_priv_mode #(.MODE_W(MODE_W)) i_priv_mode (
    .fetch_i    (req_fetch_i),
    .priv_i     (priv_i),
    .mprv_i     (mprv_i),
    .mpp_i      (mpp_i),
    .mode_i     (satp_mode_i),
    .eff_priv_o (eff_priv),
    .bare_o     (is_bare),
    .sv39_o     (is_sv39),
    .bad_o      (is_bad)
  );

  // permission and A/D check on hit or walk leaf
  logic [PTE_W-1:0]  pte_sel, pte_upd;
  logic [FLAG_W-1:0] flags_upd;
  logic              perm_ok, upd_need;

  assign pte_sel = (state_q == ST_LKP) ? tlb_pte_i : walk_pte_i;
  assign pte_upd = {pte_sel[PTE_W-1:FLAG_W], flags_upd};

  atc_pte_chk i_pte_chk (
    .acc_i       (acc_q),
    .priv_i      (priv_q),
    .mxr_i       (mxr_q),
    .sum_i       (sum_q),
    .flags_i     (pte_sel[FLAG_W-1:0]),
    .perm_ok_o   (perm_ok),
    .upd_need_o  (upd_need),
    .flags_upd_o (flags_upd)
  );

  fault_kind_e       kind;
  logic [4:0]        cause;

  always_comb begin
    kind = FK_PAGE;
    if (state_q == ST_MEMW) kind = FK_ACCESS;
    else if (state_q == ST_WALK && !walk_ok_i && walk_err_i == WERR_ACCESS) kind = FK_ACCESS;
  end

  atc_cause i_cause (
    .acc_i   (acc_q),
    .kind_i  (kind),
    .cause_o (cause)
  );

  // write-back policy
  logic wb_en;
  generate
    if (UPD_AD) begin : g_wb
      assign wb_en = 1'b1;
    end else begin : g_fault
      assign wb_en = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      va_q         <= '0;
      acc_q        <= ACC_READ;
      priv_q       <= PRIV_U;
      mxr_q        <= 1'b0;
      sum_q        <= 1'b0;
      asid_q       <= '0;
      pte_q        <= '0;
      pte_addr_q   <= '0;
      pa_q         <= '0;
      lvl_q        <= '0;
      glob_q       <= 1'b0;
      rsp_valid_q  <= 1'b0;
      rsp_fault_q  <= 1'b0;
      rsp_cause_q  <= '0;
      rsp_paddr_q  <= '0;
      cfg_err_q    <= 1'b0;
      fill_valid_q <= 1'b0;
    end else begin
      rsp_valid_q  <= 1'b0;
      cfg_err_q    <= 1'b0;
      fill_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q   <= req_vaddr_i[SV_VA_W-1:0];
            acc_q  <= acc_e'(req_acc_i);
            priv_q <= eff_priv;
            mxr_q  <= mxr_i;
            sum_q  <= sum_i;
            asid_q <= satp_asid_i;
            if (is_bare) begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b0;
              rsp_paddr_q <= req_vaddr_i;
            end else if (is_bad) begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b0;
              cfg_err_q   <= 1'b1;
            end else if (is_sv39) begin
              state_q <= ST_LKP;
            end
          end
        end
        ST_LKP: begin
          if (tlb_rsp_valid_i) begin
            if (!tlb_hit_i) begin
              state_q <= ST_WALK;
            end else if (!perm_ok || (upd_need && !wb_en)) begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
              rsp_cause_q <= cause;
              state_q     <= ST_IDLE;
            end else if (upd_need) begin
              pte_q      <= pte_upd;
              pte_addr_q <= tlb_pte_addr_i;
              pa_q       <= tlb_paddr_i;
              lvl_q      <= tlb_level_i;
              glob_q     <= tlb_global_i;
              state_q    <= ST_MEMW;
            end else begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b0;
              rsp_paddr_q <= {{PAD_W{1'b0}}, tlb_paddr_i};
              state_q     <= ST_IDLE;
            end
          end
        end
        ST_WALK: begin
          if (walk_rsp_valid_i) begin
            if (!walk_ok_i || !perm_ok || (upd_need && !wb_en)) begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
              rsp_cause_q <= cause;
              state_q     <= ST_IDLE;
            end else begin
              pte_q      <= upd_need ? pte_upd : walk_pte_i;
              pte_addr_q <= walk_pte_addr_i;
              pa_q       <= walk_paddr_i;
              lvl_q      <= walk_level_i;
              glob_q     <= walk_global_i;
              if (upd_need) begin
                state_q <= ST_MEMW;
              end else begin
                rsp_valid_q  <= 1'b1;
                rsp_fault_q  <= 1'b0;
                rsp_paddr_q  <= {{PAD_W{1'b0}}, walk_paddr_i};
                fill_valid_q <= 1'b1;
                state_q      <= ST_IDLE;
              end
            end
          end
        end
        ST_MEMW: begin
          if (mem_wr_done_i) begin
            rsp_valid_q <= 1'b1;
            state_q     <= ST_IDLE;
            if (mem_wr_err_i) begin
              rsp_fault_q <= 1'b1;
              rsp_cause_q <= cause;
            end else begin
              rsp_fault_q  <= 1'b0;
              rsp_paddr_q  <= {{PAD_W{1'b0}}, pa_q};
              fill_valid_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o      = (state_q == ST_IDLE);
  assign rsp_valid_o      = rsp_valid_q;
  assign rsp_paddr_o      = rsp_paddr_q;
  assign rsp_fault_o      = rsp_fault_q;
  assign rsp_cause_o      = rsp_cause_q;
  assign cfg_err_o        = cfg_err_q;

  assign tlb_req_valid_o  = (state_q == ST_LKP);
  assign tlb_vaddr_o      = va_q;
  assign tlb_asid_o       = asid_q;

  assign walk_req_valid_o = (state_q == ST_WALK);
  assign walk_vaddr_o     = va_q;
  assign walk_level_o     = LVL_TOP;

  assign mem_wr_valid_o   = (state_q == ST_MEMW);
  assign mem_wr_addr_o    = pte_addr_q;
  assign mem_wr_data_o    = pte_q;

  assign tlb_fill_valid_o    = fill_valid_q;
  assign tlb_fill_vaddr_o    = va_q;
  assign tlb_fill_asid_o     = asid_q;
  assign tlb_fill_paddr_o    = pa_q;
  assign tlb_fill_pte_o      = pte_q;
  assign tlb_fill_pte_addr_o = pte_addr_q;
  assign tlb_fill_level_o    = lvl_q;
  assign tlb_fill_global_o   = glob_q;
endmodule

// File: rtl/atc_ctrl_chk.sv
module atc_ctrl_chk #(
  parameter int unsigned XLEN      = 64,
  parameter int unsigned MODE_W    = 4,
  parameter int unsigned LVL_W     = 2,
  parameter int unsigned START_LVL = 2,
  parameter bit          UPD_AD    = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [XLEN-1:0]   req_vaddr_i,
  input logic              req_fetch_i,
  input logic [1:0]        priv_i,
  input logic              mprv_i,
  input logic [1:0]        mpp_i,
  input logic [MODE_W-1:0] satp_mode_i,
  input logic              rsp_valid_o,
  input logic              rsp_fault_o,
  input logic [XLEN-1:0]   rsp_paddr_o,
  input logic              cfg_err_o,
  input logic              tlb_req_valid_o,
  input logic              walk_req_valid_o,
  input logic              walk_rsp_valid_i,
  input logic [LVL_W-1:0]  walk_level_o,
  input logic              mem_wr_valid_o,
  input logic              mem_wr_done_i,
  input logic              mem_wr_err_i,
  input logic              tlb_fill_valid_o,
  input logic              fill_a_i
);
  logic [1:0] chk_priv;
  logic       chk_m, accept;
  assign chk_priv = req_fetch_i ? priv_i : (mprv_i ? mpp_i : priv_i);
  assign chk_m    = (chk_priv == 2'd3);
  assign accept   = req_valid_i && req_ready_o;

  AST_BARE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (chk_m || satp_mode_i == '0) |=> rsp_valid_o && !rsp_fault_o && !cfg_err_o
      && rsp_paddr_o == $past(req_vaddr_i)) else $error("bare pass"); // R2
  AST_BAD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !chk_m && satp_mode_i != '0 && satp_mode_i != MODE_W'(8) |=> rsp_valid_o && cfg_err_o)
    else $error("bad mode"); // R11
  AST_CFG_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> rsp_valid_o && !rsp_fault_o && !tlb_req_valid_o) else $error("cfg"); // R11
  AST_ONE_DOWNSTREAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tlb_req_valid_o, walk_req_valid_o, mem_wr_valid_o})) else $error("onehot"); // R12
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tlb_req_valid_o || walk_req_valid_o || mem_wr_valid_o) |-> !req_ready_o) else $error("ready"); // R12
  AST_WALK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_valid_o && !walk_rsp_valid_i |=> walk_req_valid_o) else $error("hold"); // R12
  AST_WALK_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_valid_o |-> walk_level_o == LVL_W'(START_LVL)) else $error("level"); // R6
  AST_FILL_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_fill_valid_o |-> rsp_valid_o && !rsp_fault_o && fill_a_i) else $error("fill"); // R6
  AST_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !UPD_AD |-> !mem_wr_valid_o) else $error("wb"); // R7
  AST_WR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o && mem_wr_done_i && mem_wr_err_i |=> rsp_valid_o && rsp_fault_o && !tlb_fill_valid_o)
    else $error("wr err"); // R8
endmodule

bind atc_ctrl atc_ctrl_chk #(
  .XLEN(XLEN), .MODE_W(MODE_W), .LVL_W(LVL_W), .START_LVL(START_LVL), .UPD_AD(UPD_AD)
) i_atc_ctrl_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_valid_i      (req_valid_i),
  .req_ready_o      (req_ready_o),
  .req_vaddr_i      (req_vaddr_i),
  .req_fetch_i      (req_fetch_i),
  .priv_i           (priv_i),
  .mprv_i           (mprv_i),
  .mpp_i            (mpp_i),
  .satp_mode_i      (satp_mode_i),
  .rsp_valid_o      (rsp_valid_o),
  .rsp_fault_o      (rsp_fault_o),
  .rsp_paddr_o      (rsp_paddr_o),
  .cfg_err_o        (cfg_err_o),
  .tlb_req_valid_o  (tlb_req_valid_o),
  .walk_req_valid_o (walk_req_valid_o),
  .walk_rsp_valid_i (walk_rsp_valid_i),
  .walk_level_o     (walk_level_o),
  .mem_wr_valid_o   (mem_wr_valid_o),
  .mem_wr_done_i    (mem_wr_done_i),
  .mem_wr_err_i     (mem_wr_err_i),
  .tlb_fill_valid_o (tlb_fill_valid_o),
  .fill_a_i         (tlb_fill_pte_o[6])
);

// File: tb/test_atc_ctrl.sv
module test_atc_ctrl;
  localparam int unsigned CLK_PERIOD = 10;

  typedef struct {
    int          tag;
    bit          fault;
    bit [4:0]    cause;
    bit          cfg;
    bit [63:0]   paddr;
    bit          fill;
    bit [63:0]   fpte;
    bit          wr;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0;
  int n_fail = 0;

  // shared stimulus
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = 2'd0;
  logic        req_fetch = 1'b0;
  logic [1:0]  priv = 2'd1;
  logic        mprv = 1'b0;
  logic [1:0]  mpp = 2'd0;
  logic        mxr = 1'b0;
  logic        sum = 1'b0;
  logic [3:0]  mode = 4'd8;
  logic [15:0] asid = 16'h0;

  // downstream model data
  logic        s_hit = 1'b0;
  logic [63:0] s_tlb_pte = '0;
  logic [55:0] s_tlb_pa = '0;
  logic [55:0] s_tlb_pte_addr = '0;
  logic        s_walk_ok = 1'b1;
  logic [1:0]  s_walk_err = 2'd0;
  logic [63:0] s_walk_pte = '0;
  logic [55:0] s_walk_pa = '0;
  logic [55:0] s_walk_pte_addr = '0;
  logic        s_mem_err = 1'b0;

  // per-instance wires: index 0 = write-back build, 1 = fault build
  logic        ready [2];
  logic        rv [2];
  logic [63:0] rpa [2];
  logic        rf [2];
  logic [4:0]  rc [2];
  logic        cfg [2];
  logic        tq [2];
  logic [38:0] tva [2];
  logic [15:0] tas [2];
  logic        wq [2];
  logic [38:0] wva [2];
  logic [1:0]  wlv [2];
  logic        mw [2];
  logic [55:0] mwa [2];
  logic [63:0] mwd [2];
  logic        fv [2];
  logic [38:0] fva [2];
  logic [15:0] fas [2];
  logic [55:0] fpa [2];
  logic [63:0] fpte [2];
  logic [55:0] fpad [2];
  logic [1:0]  flv [2];
  logic        fgl [2];

  atc_ctrl #(.UPD_AD(1'b1)) i_atc_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(ready[0]), .req_vaddr_i(req_va), .req_acc_i(req_acc),
    .req_fetch_i(req_fetch), .priv_i(priv), .mprv_i(mprv), .mpp_i(mpp), .mxr_i(mxr), .sum_i(sum),
    .satp_mode_i(mode), .satp_asid_i(asid),
    .rsp_valid_o(rv[0]), .rsp_paddr_o(rpa[0]), .rsp_fault_o(rf[0]), .rsp_cause_o(rc[0]), .cfg_err_o(cfg[0]),
    .tlb_req_valid_o(tq[0]), .tlb_vaddr_o(tva[0]), .tlb_asid_o(tas[0]),
    .tlb_rsp_valid_i(tq[0]), .tlb_hit_i(s_hit), .tlb_pte_i(s_tlb_pte), .tlb_paddr_i(s_tlb_pa),
    .tlb_pte_addr_i(s_tlb_pte_addr), .tlb_level_i(2'd0), .tlb_global_i(1'b0),
    .walk_req_valid_o(wq[0]), .walk_vaddr_o(wva[0]), .walk_level_o(wlv[0]),
    .walk_rsp_valid_i(wq[0]), .walk_ok_i(s_walk_ok), .walk_err_i(s_walk_err), .walk_pte_i(s_walk_pte),
    .walk_paddr_i(s_walk_pa), .walk_pte_addr_i(s_walk_pte_addr), .walk_level_i(2'd0), .walk_global_i(1'b0),
    .mem_wr_valid_o(mw[0]), .mem_wr_addr_o(mwa[0]), .mem_wr_data_o(mwd[0]),
    .mem_wr_done_i(mw[0]), .mem_wr_err_i(s_mem_err),
    .tlb_fill_valid_o(fv[0]), .tlb_fill_vaddr_o(fva[0]), .tlb_fill_asid_o(fas[0]), .tlb_fill_paddr_o(fpa[0]),
    .tlb_fill_pte_o(fpte[0]), .tlb_fill_pte_addr_o(fpad[0]), .tlb_fill_level_o(flv[0]),
    .tlb_fill_global_o(fgl[0])
  );

  atc_ctrl #(.UPD_AD(1'b0)) i_atc_ctrl_noupd (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(ready[1]), .req_vaddr_i(req_va), .req_acc_i(req_acc),
    .req_fetch_i(req_fetch), .priv_i(priv), .mprv_i(mprv), .mpp_i(mpp), .mxr_i(mxr), .sum_i(sum),
    .satp_mode_i(mode), .satp_asid_i(asid),
    .rsp_valid_o(rv[1]), .rsp_paddr_o(rpa[1]), .rsp_fault_o(rf[1]), .rsp_cause_o(rc[1]), .cfg_err_o(cfg[1]),
    .tlb_req_valid_o(tq[1]), .tlb_vaddr_o(tva[1]), .tlb_asid_o(tas[1]),
    .tlb_rsp_valid_i(tq[1]), .tlb_hit_i(s_hit), .tlb_pte_i(s_tlb_pte), .tlb_paddr_i(s_tlb_pa),
    .tlb_pte_addr_i(s_tlb_pte_addr), .tlb_level_i(2'd0), .tlb_global_i(1'b0),
    .walk_req_valid_o(wq[1]), .walk_vaddr_o(wva[1]), .walk_level_o(wlv[1]),
    .walk_rsp_valid_i(wq[1]), .walk_ok_i(s_walk_ok), .walk_err_i(s_walk_err), .walk_pte_i(s_walk_pte),
    .walk_paddr_i(s_walk_pa), .walk_pte_addr_i(s_walk_pte_addr), .walk_level_i(2'd0), .walk_global_i(1'b0),
    .mem_wr_valid_o(mw[1]), .mem_wr_addr_o(mwa[1]), .mem_wr_data_o(mwd[1]),
    .mem_wr_done_i(mw[1]), .mem_wr_err_i(s_mem_err),
    .tlb_fill_valid_o(fv[1]), .tlb_fill_vaddr_o(fva[1]), .tlb_fill_asid_o(fas[1]), .tlb_fill_paddr_o(fpa[1]),
    .tlb_fill_pte_o(fpte[1]), .tlb_fill_pte_addr_o(fpad[1]), .tlb_fill_level_o(flv[1]),
    .tlb_fill_global_o(fgl[1])
  );

  exp_t qa[$];
  exp_t qb[$];
  int   wr_cnt [2] = '{0, 0};
  int   wr_base [2] = '{0, 0};

  always @(posedge clk) begin
    if (mw[0]) wr_cnt[0] <= wr_cnt[0] + 1;
    if (mw[1]) wr_cnt[1] <= wr_cnt[1] + 1;
  end

  task automatic compare(input int k, input exp_t e);
    bit bad;
    n_run++;
    bad = (rf[k] != e.fault) || (cfg[k] != e.cfg) || (fv[k] != e.fill)
       || ((wr_cnt[k] != wr_base[k]) != e.wr);
    if (e.fault && rc[k] != e.cause) bad = 1'b1;
    if (!e.fault && !e.cfg && rpa[k] != e.paddr) bad = 1'b1;
    if (e.fill && fpte[k] != e.fpte) bad = 1'b1;
    if (bad) begin
      n_fail++;
      $display("FAIL R%0d inst%0d: got fault=%0b cause=%0d cfg=%0b pa=%h fill=%0b fpte=%h wr=%0b exp fault=%0b cause=%0d cfg=%0b pa=%h fill=%0b fpte=%h wr=%0b",
        e.tag, k, rf[k], rc[k], cfg[k], rpa[k], fv[k], fpte[k], wr_cnt[k] != wr_base[k],
        e.fault, e.cause, e.cfg, e.paddr, e.fill, e.fpte, e.wr);
    end
    wr_base[k] = wr_cnt[k];
  endtask

  task automatic unexpected(input int k);
    n_run++;
    n_fail++;
    $display("FAIL R12 inst%0d: got unexpected response, exp none", k);
  endtask

  // monitor: scoreboard pop and downstream request checks
  always @(negedge clk) begin
    if (rst_ni) begin
      if (rv[0]) begin
        if (qa.size() == 0) unexpected(0);
        else compare(0, qa.pop_front());
      end
      if (rv[1]) begin
        if (qb.size() == 0) unexpected(1);
        else compare(1, qb.pop_front());
      end
      if (tq[0]) begin // R3
        n_run++;
        if (tva[0] != req_va[38:0] || tas[0] != asid) begin
          n_fail++;
          $display("FAIL R3: got va=%h asid=%h exp va=%h asid=%h", tva[0], tas[0], req_va[38:0], asid);
        end
      end
      if (wq[0]) begin // R6
        n_run++;
        if (wva[0] != req_va[38:0] || wlv[0] != 2'd2) begin
          n_fail++;
          $display("FAIL R6: got va=%h lvl=%0d exp va=%h lvl=2", wva[0], wlv[0], req_va[38:0]);
        end
      end
    end
  end

  function automatic exp_t e_pa(int tag, bit [63:0] pa, bit fill, bit [63:0] fp, bit wr);
    exp_t e;
    e.tag = tag; e.fault = 0; e.cause = 0; e.cfg = 0; e.paddr = pa; e.fill = fill; e.fpte = fp; e.wr = wr;
    return e;
  endfunction

  function automatic exp_t e_flt(int tag, bit [4:0] c, bit wr);
    exp_t e;
    e.tag = tag; e.fault = 1; e.cause = c; e.cfg = 0; e.paddr = '0; e.fill = 0; e.fpte = '0; e.wr = wr;
    return e;
  endfunction

  function automatic exp_t e_cfg(int tag);
    exp_t e;
    e.tag = tag; e.fault = 0; e.cause = 0; e.cfg = 1; e.paddr = '0; e.fill = 0; e.fpte = '0; e.wr = 0;
    return e;
  endfunction

  // flags: V0 R1 W2 X3 U4 G5 A6 D7
  function automatic logic [63:0] mk_pte(logic [43:0] ppn, logic [7:0] fl);
    return {10'd0, ppn, 2'b00, fl};
  endfunction

  task automatic go(input exp_t ea, input exp_t eb);
    qa.push_back(ea);
    qb.push_back(eb);
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (qa.size() != 0 || qb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000) begin
      n_run++;
      n_fail++;
      $display("FAIL R12: watchdog expired, got hang exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  localparam logic [7:0] F_V = 8'h01, F_R = 8'h02, F_W = 8'h04, F_X = 8'h08;
  localparam logic [7:0] F_U = 8'h10, F_A = 8'h40, F_D = 8'h80;

  initial begin
    logic [63:0] p;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin // reset state, R12
      n_run++;
      if (rv[k] !== 1'b0 || ready[k] !== 1'b1 || tq[k] !== 1'b0) begin
        n_fail++;
        $display("FAIL R12 inst%0d: got rv=%b ready=%b exp rv=0 ready=1", k, rv[k], ready[k]);
      end
    end

    // R2: machine privilege bypass even with Sv39 selected
    priv = 2'd3; mode = 4'd8; req_va = 64'hDEAD_BEEF_1234_5678;
    go(e_pa(2, req_va, 0, 0, 0), e_pa(2, req_va, 0, 0, 0));
    // R2: bare mode for supervisor
    priv = 2'd1; mode = 4'd0; req_va = 64'hFFFF_0000_ABCD_0123;
    go(e_pa(2, req_va, 0, 0, 0), e_pa(2, req_va, 0, 0, 0));
    // R1: data access borrows M through mprv -> bare
    mode = 4'd8; mprv = 1'b1; mpp = 2'd3; req_acc = 2'd0; req_fetch = 1'b0; req_va = 64'h0000_0040_0000_1000;
    go(e_pa(1, req_va, 0, 0, 0), e_pa(1, req_va, 0, 0, 0));
    // R1/R3: fetch ignores mprv -> Sv39 hit, upper VA bits ignored
    req_fetch = 1'b1; req_acc = 2'd2; asid = 16'hBEEF; req_va = 64'hFFFF_FFC0_1234_5000;
    s_hit = 1'b1; s_tlb_pte = mk_pte(44'h80001, F_V | F_X | F_A); s_tlb_pa = 56'h8000_1000;
    go(e_pa(1, 64'h8000_1000, 0, 0, 0), e_pa(1, 64'h8000_1000, 0, 0, 0));
    req_fetch = 1'b0; mprv = 1'b0; mpp = 2'd0;
    // R11: unsupported mode
    mode = 4'd9;
    go(e_cfg(11), e_cfg(11));
    mode = 4'd8; req_acc = 2'd0;
    // R4/R5: user read of supervisor page
    priv = 2'd0; s_tlb_pte = mk_pte(44'h80002, F_V | F_R | F_A); s_tlb_pa = 56'h8000_2010;
    go(e_flt(4, 5'd13, 0), e_flt(4, 5'd13, 0));
    // R5: supervisor read of user page, sum off then on
    priv = 2'd1; s_tlb_pte = mk_pte(44'h80002, F_V | F_R | F_U | F_A);
    go(e_flt(5, 5'd13, 0), e_flt(5, 5'd13, 0));
    sum = 1'b1;
    go(e_pa(5, 64'h8000_2010, 0, 0, 0), e_pa(5, 64'h8000_2010, 0, 0, 0));
    sum = 1'b0;
    // R5: execute-only page, mxr off then on
    s_tlb_pte = mk_pte(44'h80002, F_V | F_X | F_A);
    go(e_flt(5, 5'd13, 0), e_flt(5, 5'd13, 0));
    mxr = 1'b1;
    go(e_pa(5, 64'h8000_2010, 0, 0, 0), e_pa(5, 64'h8000_2010, 0, 0, 0));
    mxr = 1'b0;
    // R5: supervisor execute of user page
    req_acc = 2'd2; s_tlb_pte = mk_pte(44'h80002, F_V | F_X | F_U | F_A);
    go(e_flt(5, 5'd12, 0), e_flt(5, 5'd12, 0));
    // R7/R8: write hit with D clear
    req_acc = 2'd1; p = mk_pte(44'h80003, F_V | F_R | F_W | F_A);
    s_tlb_pte = p; s_tlb_pa = 56'h8000_3abc; s_tlb_pte_addr = 56'h1000_0018;
    go(e_pa(8, 64'h8000_3abc, 1, p | 64'(F_D), 1), e_flt(7, 5'd15, 0));
    // R6: miss, walk ok, no update
    s_hit = 1'b0; req_acc = 2'd0; p = mk_pte(44'h80004, F_V | F_R | F_A);
    s_walk_ok = 1'b1; s_walk_pte = p; s_walk_pa = 56'h8000_4020; s_walk_pte_addr = 56'h1000_0020;
    go(e_pa(6, 64'h8000_4020, 1, p, 0), e_pa(6, 64'h8000_4020, 1, p, 0));
    // R5: walk result permission failure (store to read-only)
    req_acc = 2'd1;
    go(e_flt(5, 5'd15, 0), e_flt(5, 5'd15, 0));
    // R7/R8: walk result with A clear, write-back ok
    req_acc = 2'd0; p = mk_pte(44'h80005, F_V | F_R);
    s_walk_pte = p; s_walk_pa = 56'h8000_5000;
    go(e_pa(8, 64'h8000_5000, 1, p | 64'(F_A), 1), e_flt(7, 5'd13, 0));
    // R8: write-back error gives access fault
    s_mem_err = 1'b1;
    go(e_flt(8, 5'd5, 1), e_flt(7, 5'd13, 0));
    s_mem_err = 1'b0;
    // R9/R10: walker failures crossed with access types
    s_walk_ok = 1'b0; s_walk_err = 2'd0; req_acc = 2'd2; req_fetch = 1'b1;
    go(e_flt(9, 5'd12, 0), e_flt(9, 5'd12, 0));
    s_walk_err = 2'd2;
    go(e_flt(10, 5'd1, 0), e_flt(10, 5'd1, 0));
    req_fetch = 1'b0; req_acc = 2'd0;
    go(e_flt(10, 5'd5, 0), e_flt(10, 5'd5, 0));
    req_acc = 2'd1;
    go(e_flt(10, 5'd7, 0), e_flt(10, 5'd7, 0));
    s_walk_err = 2'd1;
    go(e_flt(9, 5'd15, 0), e_flt(9, 5'd15, 0));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule